// File: doc/BRIEF.md
# Synthesiser Programming Port (I2C Slave)

This block is the serial programming front end of a frequency synthesiser. It watches an I2C bus (SCL and SDA already sampled into the core clock domain), answers to a seven-bit address whose two low bits come from an external select input, and acknowledges every byte addressed to it. Bytes written after the address are sorted by their leading bit. A leading 0 opens a divider pair, which carries a 15-bit division ratio. A leading 1 opens a control/port pair, which carries charge-pump, test and drive-disable bits followed by an eight-bit output port latch.

A read returns a packed status byte. It holds a power-on flag, the phase-lock flag, three digital port levels and a saturated five-level ADC code. The ratio reaches the divider only as a whole, after the second byte of its pair has been acknowledged. A START or STOP at any point abandons the byte in progress and any half-received pair.

The block drives SDA through a single open-drain pull-down enable. The pad, the analog address-select decoder, the ADC comparators and the divider counter sit outside it.

Top module: `synth_ctl_if`

## Requirements
- R1: The slave answers to address bits 1,1,0,0,0,sel[1],sel[0] followed by the R/W bit (0 = write, 1 = read), sent MSB first. On a match it pulls SDA low during the ninth clock of the address byte.
- R2: A byte carrying any other address gets no acknowledge. Every byte after it is ignored, with no acknowledge and no register change, until the next START.
- R3: In a write, every data byte is acknowledged by pulling SDA low during its ninth clock.
- R4: A first data byte with bit 7 = 0 supplies ratio bits 14..8 in its bits 6..0, and the following byte supplies ratio bits 7..0. `ratio_o` changes only once, when the acknowledge clock of the second byte ends.
- R5: A first data byte with bit 7 = 1 is a control byte. Its bit 6 drives `cp_sel_o`, bits 5..4 drive `test_o[1:0]` and bit 0 drives `drive_off_o`. Bits 3..1 have no effect. The values apply when its acknowledge clock ends.
- R6: The byte after a control byte is loaded into `port_o[7:0]`.
- R7: A read returns a status byte MSB first: bit 7 power-on flag, bit 6 `lock_i`, bits 5..3 `port_in[2:0]` (P7, P5, P4), bits 2..0 the ADC code.
- R8: An ADC input code above 3'b100 is reported as 3'b100.
- R9: The power-on flag reads 1 after reset and is cleared when the acknowledge clock of a status byte ends. A later read shows 0.
- R10: A START or STOP aborts a partial byte and a half-received pair. No register changes, and the next byte is taken as an address after a START.
- R11: During a read the slave releases SDA for the master's acknowledge clock. After a NACK it keeps SDA released.
- R12: After reset the ratio and control outputs are 0, `port_o` equals `PORT_RESET`, and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Sampled SCL level |
| sda_i | input | 1 | Sampled SDA bus level |
| sda_pull_o | output | 1 | 1 = pull SDA low |
| addr_sel_i | input | 2 | Low two address bits from the select input |
| lock_i | input | 1 | Phase-lock flag |
| port_in_i | input | 3 | Digital levels of P7, P5, P4 |
| adc_i | input | 3 | ADC band code |
| ratio_o | output | 15 | Divider ratio |
| cp_sel_o | output | 1 | Charge-pump current select |
| test_o | output | 2 | Test-mode select |
| drive_off_o | output | 1 | Varactor drive disable |
| port_o | output | 8 | Output port latch |

## Verification
The bench keeps the default fixed address bits and overrides `PORT_RESET` to 8'h5A, so a latch that resets to zero or ignores the parameter is visible from the first check. It ties the address select to 2'b10. This makes the two selectable bits differ, so a swapped or dropped select bit turns a matching address into a refused one. It also drives ADC codes inside and above the legal range, which brings the saturation path within reach.

// File: rtl/synth_ctl_pkg.sv
`timescale 1ns/1ps
// Shared sizes and state types for the synthesiser programming port.
package synth_ctl_pkg;
    localparam int BYTE_W  = 8;
    localparam int SEL_W   = 2;
    localparam int FIX_W   = BYTE_W - 1 - SEL_W;
    localparam int RATIO_W = 2 * BYTE_W - 1;
    localparam int CNT_W   = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        S_IDLE, S_ADDR, S_ADDR_ACK, S_WR_BYTE, S_WR_ACK, S_RD_BYTE, S_RD_ACK
    } bus_state_e;

    typedef enum logic [1:0] {P_FIRST, P_DIV_LO, P_PORT} pair_state_e;
endpackage

// File: rtl/synth_i2c_line.sv
`timescale 1ns/1ps
// Bus condition detector: finds SCL edges and START/STOP conditions.
// Assumes scl_i/sda_i are already synchronous to clk.
module synth_i2c_line (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    logic scl_q, sda_q;

    // Hold the previous line levels (idle bus is high).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    // Classify transitions against the previous levels.
    always_comb begin
        scl_rise  = scl_i & ~scl_q;
        scl_fall  = ~scl_i & scl_q;
        bus_start = scl_q & scl_i & sda_q & ~sda_i;
        bus_stop  = scl_q & scl_i & ~sda_q & sda_i;
    end
endmodule

// File: rtl/synth_i2c_engine.sv
`timescale 1ns/1ps
// Byte engine: address match, per-byte acknowledge, write shifting and
// status transmission. Changes SDA only after a falling SCL edge.
module synth_i2c_engine
    import synth_ctl_pkg::*;
#(
    parameter logic [FIX_W-1:0] BASE_ADDR = 5'b11000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic              sda_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic [BYTE_W-1:0] status_i,
    output logic              sda_pull_o,
    output logic              byte_stb_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic              rd_done_o
);
    bus_state_e        state_q;
    logic [CNT_W-1:0]  bit_q;
    logic [BYTE_W-1:0] sh_q;
    logic              oe_q, mack_q, stb_q, rdd_q;
    logic [BYTE_W-2:0] my_addr;
    logic              last_bit;

    assign my_addr  = {BASE_ADDR, sel_i};
    assign last_bit = (bit_q == CNT_W'(BYTE_W));

    // Bus state machine, bit counter, shift register and SDA pull.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            bit_q   <= '0;
            sh_q    <= '0;
            oe_q    <= 1'b0;
            mack_q  <= 1'b0;
            stb_q   <= 1'b0;
            rdd_q   <= 1'b0;
        end else begin
            stb_q <= 1'b0;
            rdd_q <= 1'b0;
            if (bus_start) begin
                state_q <= S_ADDR;
                bit_q   <= '0;
                oe_q    <= 1'b0;
            end else if (bus_stop) begin
                state_q <= S_IDLE;
                oe_q    <= 1'b0;
            end else begin
                case (state_q)
                    S_ADDR, S_WR_BYTE: begin
                        if (scl_rise) begin
                            sh_q  <= {sh_q[BYTE_W-2:0], sda_i};
                            bit_q <= bit_q + CNT_W'(1);
                        end else if (scl_fall && last_bit) begin
                            if (state_q == S_WR_BYTE) begin
                                oe_q    <= 1'b1;
                                state_q <= S_WR_ACK;
                            end else if (sh_q[BYTE_W-1:1] == my_addr) begin
                                oe_q    <= 1'b1;
                                state_q <= S_ADDR_ACK;
                            end else begin
                                state_q <= S_IDLE;
                            end
                        end
                    end
                    S_ADDR_ACK: if (scl_fall) begin
                        bit_q <= '0;
                        if (sh_q[0]) begin
                            sh_q    <= status_i;
                            oe_q    <= ~status_i[BYTE_W-1];
                            state_q <= S_RD_BYTE;
                        end else begin
                            oe_q    <= 1'b0;
                            state_q <= S_WR_BYTE;
                        end
                    end
                    S_WR_ACK: if (scl_fall) begin
                        oe_q    <= 1'b0;
                        bit_q   <= '0;
                        stb_q   <= 1'b1;
                        state_q <= S_WR_BYTE;
                    end
                    S_RD_BYTE: begin
                        if (scl_rise) begin
                            bit_q <= bit_q + CNT_W'(1);
                        end else if (scl_fall) begin
                            if (last_bit) begin
                                oe_q    <= 1'b0;
                                state_q <= S_RD_ACK;
                            end else begin
                                sh_q <= {sh_q[BYTE_W-2:0], 1'b0};
                                oe_q <= ~sh_q[BYTE_W-2];
                            end
                        end
                    end
                    S_RD_ACK: begin
                        if (scl_rise) begin
                            mack_q <= ~sda_i;
                        end else if (scl_fall) begin
                            rdd_q <= 1'b1;
                            bit_q <= '0;
                            if (mack_q) begin
                                sh_q    <= status_i;
                                oe_q    <= ~status_i[BYTE_W-1];
                                state_q <= S_RD_BYTE;
                            end else begin
                                state_q <= S_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_pull_o = oe_q;
    assign byte_stb_o = stb_q;
    assign byte_o     = sh_q;
    assign rd_done_o  = rdd_q;

    // R11
    pull_in_owned_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_q |-> (state_q inside {S_ADDR_ACK, S_WR_ACK, S_RD_BYTE}));
    // R2
    idle_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE) |-> !oe_q);
    // R10
    start_aborts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |=> (state_q == S_ADDR && !oe_q));
endmodule

// File: rtl/synth_reg_bank.sv
`timescale 1ns/1ps
// Register bank: sorts received bytes into divider or control/port pairs,
// commits the ratio only as a whole, and packs the status byte.
module synth_reg_bank
    import synth_ctl_pkg::*;
#(
    parameter logic [BYTE_W-1:0] PORT_RESET = 8'h00
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_rst,
    input  logic               byte_stb,
    input  logic [BYTE_W-1:0]  byte_i,
    input  logic               rd_done,
    input  logic               lock_i,
    input  logic [2:0]         port_in_i,
    input  logic [2:0]         adc_i,
    output logic [RATIO_W-1:0] ratio_o,
    output logic               cp_sel_o,
    output logic [1:0]         test_o,
    output logic               drive_off_o,
    output logic [BYTE_W-1:0]  port_o,
    output logic [BYTE_W-1:0]  status_o
);
    localparam logic [2:0] ADC_TOP = 3'd4;

    pair_state_e       pair_q;
    logic [BYTE_W-2:0] hi_q;
    logic              por_q;
    logic [2:0]        adc_sat;

    // Pair sorting, register updates and power-on flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pair_q      <= P_FIRST;
            hi_q        <= '0;
            ratio_o     <= '0;
            cp_sel_o    <= 1'b0;
            test_o      <= '0;
            drive_off_o <= 1'b0;
            port_o      <= PORT_RESET;
            por_q       <= 1'b1;
        end else begin
            if (rd_done) por_q <= 1'b0;
            if (frame_rst) begin
                pair_q <= P_FIRST;
            end else if (byte_stb) begin
                case (pair_q)
                    P_FIRST: begin
                        if (byte_i[BYTE_W-1]) begin
                            cp_sel_o    <= byte_i[6];
                            test_o      <= byte_i[5:4];
                            drive_off_o <= byte_i[0];
                            pair_q      <= P_PORT;
                        end else begin
                            hi_q   <= byte_i[BYTE_W-2:0];
                            pair_q <= P_DIV_LO;
                        end
                    end
                    P_DIV_LO: begin
                        ratio_o <= {hi_q, byte_i};
                        pair_q  <= P_FIRST;
                    end
                    default: begin
                        port_o <= byte_i;
                        pair_q <= P_FIRST;
                    end
                endcase
            end
        end
    end

    // Saturate the ADC code and pack the status byte.
    always_comb begin
        adc_sat  = (adc_i > ADC_TOP) ? ADC_TOP : adc_i;
        status_o = {por_q, lock_i, port_in_i, adc_sat};
    end

    // R4
    ratio_atomic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_stb |=> $stable(ratio_o));
    // R9
    por_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(por_q) |-> $past(rd_done));
    // R8
    adc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[2:0] <= ADC_TOP);
endmodule

// File: rtl/synth_ctl_if.sv
`timescale 1ns/1ps
// Top: I2C programming port of a frequency synthesiser. Connects the line
// detector, byte engine and register bank. Assumes sampled SCL/SDA inputs
// and an external open-drain pad driven by sda_pull_o.
module synth_ctl_if
    import synth_ctl_pkg::*;
#(
    parameter logic [FIX_W-1:0]  BASE_ADDR  = 5'b11000,
    parameter logic [BYTE_W-1:0] PORT_RESET = 8'h00
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_pull_o,
    input  logic [SEL_W-1:0]   addr_sel_i,
    input  logic               lock_i,
    input  logic [2:0]         port_in_i,
    input  logic [2:0]         adc_i,
    output logic [RATIO_W-1:0] ratio_o,
    output logic               cp_sel_o,
    output logic [1:0]         test_o,
    output logic               drive_off_o,
    output logic [BYTE_W-1:0]  port_o
);
    logic scl_rise, scl_fall, bus_start, bus_stop;
    logic byte_stb, rd_done;
    logic [BYTE_W-1:0] rx_byte, status;

    synth_i2c_line u_line (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .bus_start(bus_start), .bus_stop(bus_stop)
    );

    synth_i2c_engine #(.BASE_ADDR(BASE_ADDR)) u_engine (
        .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .bus_start(bus_start), .bus_stop(bus_stop), .sda_i(sda_i),
        .sel_i(addr_sel_i), .status_i(status), .sda_pull_o(sda_pull_o),
        .byte_stb_o(byte_stb), .byte_o(rx_byte), .rd_done_o(rd_done)
    );

    synth_reg_bank #(.PORT_RESET(PORT_RESET)) u_regs (
        .clk(clk), .rst_n(rst_n), .frame_rst(bus_start | bus_stop),
        .byte_stb(byte_stb), .byte_i(rx_byte), .rd_done(rd_done),
        .lock_i(lock_i), .port_in_i(port_in_i), .adc_i(adc_i),
        .ratio_o(ratio_o), .cp_sel_o(cp_sel_o), .test_o(test_o),
        .drive_off_o(drive_off_o), .port_o(port_o), .status_o(status)
    );
endmodule

// File: tb/tb_synth_ctl_if.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected values, the monitor pops and compares.
module tb_synth_ctl_if;
    logic        clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
    logic [1:0]  sel = 2'b10;
    logic        lock = 1'b0;
    logic [2:0]  pin = 3'b000, adc = 3'b000;
    logic        sda_pull, cp, off;
    logic [1:0]  tst;
    logic [14:0] ratio;
    logic [7:0]  port;
    wire         sda_line = sda_m & ~sda_pull;

    int checks = 0, errors = 0;
    bit done = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        obs_stb = 1'b0;
    logic [31:0] obs_val, mon_exp;
    string       mon_tag;

    always #2 clk = ~clk;

    synth_ctl_if #(.PORT_RESET(8'h5A)) dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_pull_o(sda_pull), .addr_sel_i(sel), .lock_i(lock),
        .port_in_i(pin), .adc_i(adc), .ratio_o(ratio), .cp_sel_o(cp),
        .test_o(tst), .drive_off_o(off), .port_o(port)
    );

    // Monitor: pop the expected item and compare with the observed value.
    always @(posedge clk) begin
        if (obs_stb) begin
            mon_exp = exp_q.pop_front();
            mon_tag = tag_q.pop_front();
            checks++;
            if (obs_val !== mon_exp) begin
                errors++;
                $display("FAIL %s: actual %0h expected %0h", mon_tag, obs_val, mon_exp);
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        obs_val = act;
        obs_stb = 1'b1;
        @(negedge clk);
        obs_stb = 1'b0;
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(4); scl = 1'b1; wq(4);
        sda_m = 1'b0; wq(4); scl = 1'b0; wq(4);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(4); scl = 1'b1; wq(4); sda_m = 1'b1; wq(4);
    endtask

    task automatic clock_bit(input logic b, output logic seen);
        sda_m = b; wq(4); scl = 1'b1; wq(4);
        seen = sda_line; wq(4); scl = 1'b0; wq(4);
    endtask

    task automatic put_byte(input logic [7:0] d, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clock_bit(d[i], s);
        clock_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic get_byte(input logic mack, output logic [7:0] d, output logic ninth);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clock_bit(1'b1, s);
            d[i] = s;
        end
        clock_bit(~mack, ninth);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic ack, ninth;
        logic [7:0] d;
        wq(5); rst_n = 1'b1; wq(3);
        // R12 reset state
        check("R12 ratio", 32'(ratio), 0);
        check("R12 ctrl", {29'd0, cp, tst}, 0);
        check("R12 off", 32'(off), 0);
        check("R12 port", 32'(port), 32'h5A);
        check("R12 sda", 32'(sda_pull), 0);

        // R1 R3 R4 divider pair
        bus_start();
        put_byte(8'hC4, ack); check("R1 addr ack", 32'(ack), 1);
        put_byte(8'h12, ack); check("R3 ack hi", 32'(ack), 1);
        check("R4 no half update", 32'(ratio), 0);
        put_byte(8'h34, ack); check("R3 ack lo", 32'(ack), 1);
        check("R4 ratio", 32'(ratio), 32'h1234);
        bus_stop();

        // R5 R6 control then port
        bus_start();
        put_byte(8'hC4, ack);
        put_byte(8'hEF, ack);
        check("R5 ctrl EF", {28'd0, cp, tst, off}, 32'b1101);
        put_byte(8'hA5, ack);
        check("R6 port", 32'(port), 32'hA5);
        bus_stop();
        bus_start();
        put_byte(8'hC4, ack);
        put_byte(8'h90, ack);
        check("R5 ctrl 90 fixed bits ignored", {28'd0, cp, tst, off}, 32'b0010);
        bus_stop();
        check("R5 port kept", 32'(port), 32'hA5);

        // R2 wrong address
        bus_start();
        put_byte(8'hC0, ack); check("R2 no addr ack", 32'(ack), 0);
        put_byte(8'h7F, ack); check("R2 no data ack", 32'(ack), 0);
        put_byte(8'hFF, ack);
        bus_stop();
        check("R2 ratio kept", 32'(ratio), 32'h1234);
        check("R2 ctrl kept", {28'd0, cp, tst, off}, 32'b0010);

        // R10 abort mid-byte and mid-pair
        bus_start();
        put_byte(8'hC4, ack);
        put_byte(8'h01, ack);
        for (int i = 0; i < 4; i++) clock_bit(1'b1, ninth);
        bus_stop();
        check("R10 stop mid byte", 32'(ratio), 32'h1234);
        bus_start();
        put_byte(8'hC4, ack);
        put_byte(8'h01, ack);
        bus_start();
        put_byte(8'hC4, ack); check("R10 addr after restart", 32'(ack), 1);
        put_byte(8'h56, ack);
        check("R10 pair dropped", 32'(ratio), 32'h1234);
        put_byte(8'h78, ack);
        check("R10 fresh pair", 32'(ratio), 32'h5678);
        bus_stop();

        // R7 R11 status read with NACK
        lock = 1'b1; pin = 3'b101; adc = 3'b011;
        bus_start();
        put_byte(8'hC5, ack); check("R1 read addr ack", 32'(ack), 1);
        get_byte(1'b0, d, ninth);
        check("R7 status", 32'(d), 32'hEB);
        check("R11 ninth released", 32'(ninth), 1);
        check("R11 stays released", 32'(sda_pull), 0);
        bus_stop();

        // R8 R9 second read
        adc = 3'b110; pin = 3'b010; lock = 1'b0;
        bus_start();
        put_byte(8'hC5, ack);
        get_byte(1'b0, d, ninth);
        check("R9 R8 status", 32'(d), 32'h14);
        bus_stop();

        wq(4);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule